// File: doc/BRIEF.md
# Per-Line Input Glitch Filter

This block is the input side of a 32-line parallel I/O bank. Each pad level goes through an optional glitch filter, and the filter on each line can be switched on or off by itself. The filter samples the pad on both edges of the master clock. A new level is accepted only when two samples taken on consecutive, opposite edges agree. A pulse that reaches only one edge is therefore dropped, and a pulse that spans a full clock period always gets through. For each line, the filtered level (or the raw level, when that line's filter is off) forms the pin-data word. A one-cycle change pulse is raised on any line whose pin-data bit changes, and this pulse feeds an input-change interrupt stage that lives outside the block.

Software reaches the block over an APB-style bus with two phases. Writing 1s to the filter-set register turns filters on. Writing 1s to the filter-clear register turns them off. The filter status register and the pin-data word can both be read. A clock-enable input models gating of the controller clock: while it is low, the filters, the pin-data word and the change pulses all hold. The raw pad levels are passed straight to peripheral inputs, unfiltered and never frozen.

Top module: `pio_glitch_in`

## Requirements
- R1: After reset every filter is off and the filter status register (index 2, byte address 0x8) reads 0. Each status bit enables the filter of the line with the same number, and only that line.
- R2: Writing a word to the filter-set register (index 0, byte address 0x0) sets each status bit whose data bit is 1. All other status bits are left unchanged.
- R3: Writing a word to the filter-clear register (index 1, byte address 0x4) clears each status bit whose data bit is 1. All other status bits are left unchanged.
- R4: On a filtered line, a pulse shorter than half a clock period, and so seen by at most one clock edge, never changes the pin-data bit and never raises a change pulse.
- R5: On a filtered line, a pulse lasting one full clock period is always accepted. This holds whether it starts just before a rising edge or just before a falling edge.
- R6: A level change arriving just before a rising edge appears in pin data one cycle later on a filtered line than on an unfiltered line. A change arriving just before a falling edge appears at the same rising edge on both kinds of line.
- R7: Pin data (index 3, byte address 0xC) returns the current level of all 32 lines. An unfiltered line takes the pad level at each rising edge.
- R8: While clk_en is low, the pin-data word, the filters and the change pulses hold. Pin-data reads return the levels captured when the clock stopped, and chg_pulse stays 0.
- R9: periph_in always equals pad_in, whatever the filter enables and clk_en are.
- R10: chg_pulse bit i is high for exactly one cycle, directly after each change of pin-data bit i. It is 0 out of reset, and no pulse follows reset while the pads are steady.
- R11: A bus access has a setup cycle (psel high, penable low) followed by an access cycle (psel and penable high). A write takes effect only at the end of the access cycle, and read data is valid during the access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; both edges are used for sampling |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Controller clock enable; when low, filters and pin data hold |
| pad_in | input | 32 | Pad levels |
| periph_in | output | 32 | Raw pad levels passed to peripheral inputs |
| chg_pulse | output | 32 | One-cycle change pulse per line |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access-phase strobe |
| pwrite | input | 1 | Bus write when high |
| paddr | input | 4 | Byte address; bits 3:2 pick the register |
| pwdata | input | 32 | Bus write data |
| prdata | output | 32 | Bus read data |

## Verification
The bench places pulses so that each one reaches only a falling edge or only a rising edge. A filter that trusts a single sample would let these through as false pin changes. It also applies full-period pulses in both phases, which catches a filter that needs two samples from the same edge type and misses the falling-edge-aligned case. Exact-cycle sampling of the change pulses measures the rising-edge versus falling-edge latency difference, so a filter that waits one cycle too many, or too few, is reported. Random set/clear sequences and a clock-stop window with pad activity check the set/clear semantics and the freeze. The freeze check catches a design that keeps updating pin data, or that blocks the peripheral path.

// File: rtl/gin_pkg.sv
// Shared definitions for the per-line input glitch filter.
// Assumes a word-addressed register set of four entries.
package gin_pkg;
    localparam int REG_IDX_W = 2;

    typedef enum logic [REG_IDX_W-1:0] {
        IDX_FSET  = 2'd0,
        IDX_FCLR  = 2'd1,
        IDX_FSTAT = 2'd2,
        IDX_PINS  = 2'd3
    } reg_idx_e;
endpackage

// File: rtl/gin_bus_regs.sv
// Register slice for the input filter: set/clear pair for the filter
// enables, read-back of the enables and of the pin-data word.
// Assumes a two-phase bus (setup then access) with no wait states.
module gin_bus_regs
    import gin_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [LINES-1:0]  pwdata,
    input  logic [LINES-1:0]  pin_lvl,
    output logic [LINES-1:0]  prdata,
    output logic [LINES-1:0]  filt_en
);
    localparam int IDX_LSB = 2;

    reg_idx_e idx;
    logic     acc_wr;

    assign idx    = reg_idx_e'(paddr[IDX_LSB +: REG_IDX_W]);
    assign acc_wr = psel && penable && pwrite;

    // Filter enable status: set/clear writes at the end of the access phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_en <= '0;
        end else if (acc_wr) begin
            case (idx)
                IDX_FSET: filt_en <= filt_en | pwdata;
                IDX_FCLR: filt_en <= filt_en & ~pwdata;
                default:  filt_en <= filt_en;
            endcase
        end
    end

    // Read mux: status and pin data visible while selected.
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (idx)
                IDX_FSTAT: prdata = filt_en;
                IDX_PINS:  prdata = pin_lvl;
                default:   prdata = '0;
            endcase
        end
    end

    a_r2_set_ors_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && idx == IDX_FSET) |=> (filt_en == ($past(filt_en) | $past(pwdata))));

    a_r3_clear_masks_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && idx == IDX_FCLR) |=> (filt_en == ($past(filt_en) & ~$past(pwdata))));

    a_r11_setup_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |=> $stable(filt_en));
endmodule

// File: rtl/gin_line_filter.sv
// One I/O line: dual-edge sampler, glitch filter, pin-level register
// and change-pulse generator. A new filtered level is taken only when the
// samples from two consecutive opposite edges agree. Assumes pad_in is
// already in the clock domain or arrives through an upstream synchroniser.
module gin_line_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic pad,
    input  logic en,
    output logic lvl_q,
    output logic chg
);
    logic p_q;
    logic n_q;
    logic filt;
    logic filt_next;
    logic lvl_next;

    // Falling-edge sample of the pad, frozen while the clock is gated.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            n_q <= pad;
        end else if (clk_en) begin
            n_q <= pad;
        end
    end

    // Accept the falling sample when it matches the rising sample before or after it.
    always_comb begin
        filt_next = filt;
        if ((n_q == p_q) || (n_q == pad)) begin
            filt_next = n_q;
        end
        lvl_next = en ? filt_next : pad;
    end

    // Rising-edge state: raw sample, filter output, pin level, change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q   <= pad;
            filt  <= pad;
            lvl_q <= pad;
            chg   <= 1'b0;
        end else if (clk_en) begin
            p_q   <= pad;
            filt  <= filt_next;
            lvl_q <= lvl_next;
            chg   <= lvl_next ^ lvl_q;
        end else begin
            chg   <= 1'b0;
        end
    end

    a_r4_accept_needs_fall_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(filt)) |-> ($past(n_q) == filt));

    a_r8_gated_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en) |=> ($stable(lvl_q) && !chg));

    a_r10_pulse_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
        chg |-> (lvl_q != $past(lvl_q)));
endmodule

// File: rtl/pio_glitch_in.sv
// Input side of a parallel I/O bank: per-line optional glitch filters,
// pin-data word, change pulses and the bus registers that control them.
// Raw pad levels go straight to peripherals and are neither filtered
// nor frozen.
module pio_glitch_in #(
    parameter int LINES  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic [LINES-1:0]  pad_in,
    output logic [LINES-1:0]  periph_in,
    output logic [LINES-1:0]  chg_pulse,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [LINES-1:0]  pwdata,
    output logic [LINES-1:0]  prdata
);
    logic [LINES-1:0] filt_en;
    logic [LINES-1:0] pin_lvl;

    // Peripheral path: raw levels, independent of filters and clock gating.
    assign periph_in = pad_in;

    gin_bus_regs #(
        .LINES  (LINES),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .pin_lvl (pin_lvl),
        .prdata  (prdata),
        .filt_en (filt_en)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_line
        gin_line_filter u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .clk_en (clk_en),
            .pad    (pad_in[i]),
            .en     (filt_en[i]),
            .lvl_q  (pin_lvl[i]),
            .chg    (chg_pulse[i])
        );
    end
endmodule

// File: tb/sim_pio_glitch_in.sv
`timescale 1ns/1ps
module sim_pio_glitch_in;
    localparam int LINES = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clk_en = 1'b1;
    logic [LINES-1:0] pad_in = '0;
    logic [LINES-1:0] periph_in;
    logic [LINES-1:0] chg_pulse;
    logic             psel = 1'b0;
    logic             penable = 1'b0;
    logic             pwrite = 1'b0;
    logic [3:0]       paddr = '0;
    logic [LINES-1:0] pwdata = '0;
    logic [LINES-1:0] prdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pio_glitch_in u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .pad_in(pad_in),
        .periph_in(periph_in), .chg_pulse(chg_pulse), .psel(psel),
        .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .prdata(prdata)
    );

    task automatic check(input string req, input logic [LINES-1:0] act,
                         input logic [LINES-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] idx, input logic [LINES-1:0] d);
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = 1; paddr = {idx, 2'b00}; pwdata = d;
        @(posedge clk); #1;
        penable = 1;
        @(posedge clk); #1;
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_read(input logic [1:0] idx, output logic [LINES-1:0] d);
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = 0; paddr = {idx, 2'b00};
        @(posedge clk); #1;
        penable = 1;
        #0.5 d = prdata;
        @(posedge clk); #1;
        psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
    endtask

    function automatic logic [LINES-1:0] model_set(input logic [LINES-1:0] e,
                                                   input logic [LINES-1:0] d);
        return e | d;
    endfunction

    function automatic logic [LINES-1:0] model_clr(input logic [LINES-1:0] e,
                                                   input logic [LINES-1:0] d);
        return e & ~d;
    endfunction

    initial begin
        #400000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [LINES-1:0] rd;
        logic [LINES-1:0] en_m;
        logic [LINES-1:0] base;
        logic [LINES-1:0] gm;
        logic [LINES-1:0] seen;
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));

        // Reset with a non-zero steady pad word.
        pad_in = 32'hA5C3_0F96;
        idle(3);
        @(posedge clk); #1 rst_n = 1;
        check("R10 no pulse after reset", chg_pulse, '0);
        @(posedge clk); #1;
        check("R10 no pulse after reset +1", chg_pulse, '0);
        bus_read(2'd2, rd);
        check("R1 status clear after reset", rd, '0);
        bus_read(2'd3, rd);
        check("R7 pin data after reset", rd, pad_in);
        check("R9 periph raw", periph_in, pad_in);

        // R11: setup phase only, then abandoned; no write may land.
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = 1; paddr = 4'h0; pwdata = '1;
        @(posedge clk); #1;
        psel = 0; pwrite = 0;
        bus_read(2'd2, rd);
        check("R11 setup without access ignored", rd, '0);

        // Directed filter tests: line 0 filtered, line 1 not.
        pad_in = '0;
        bus_write(2'd0, 32'h0000_0001);
        en_m = 32'h1;
        bus_read(2'd2, rd);
        check("R2 set line0", rd, en_m);
        idle(4);

        // R6: change just before a rising edge.
        @(negedge clk); #1 pad_in[1:0] = 2'b11;
        @(posedge clk); #1;
        check("R6 rise-aligned first cycle", chg_pulse & 32'h3, 32'h2);
        @(posedge clk); #1;
        check("R6 rise-aligned filtered one cycle late", chg_pulse & 32'h3, 32'h1);
        idle(3);
        // R6: change just before a falling edge.
        @(posedge clk); #1 pad_in[1:0] = 2'b00;
        @(posedge clk); #1;
        check("R6 fall-aligned no extra latency", chg_pulse & 32'h3, 32'h3);
        idle(3);

        // R4: glitch reaching only a falling edge.
        seen = '0;
        @(posedge clk); #1.2 pad_in[0] = 1'b1;
        #1.6 pad_in[0] = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1 seen |= chg_pulse;
        end
        check("R4 fall-only glitch rejected", seen & 32'h1, '0);
        // R4: glitch reaching only a rising edge.
        seen = '0;
        @(negedge clk); #1.2 pad_in[0] = 1'b1;
        #1.6 pad_in[0] = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1 seen |= chg_pulse;
        end
        check("R4 rise-only glitch rejected", seen & 32'h1, '0);
        bus_read(2'd3, rd);
        check("R4 pin data unchanged", rd & 32'h1, '0);

        // R5: full-period pulse starting just before a rising edge.
        @(negedge clk); #1.5 pad_in[0] = 1'b1;
        @(negedge clk); #1.5 pad_in[0] = 1'b0;
        #1;
        check("R5 rise-phase period pulse accepted", chg_pulse & 32'h1, 32'h1);
        idle(3);
        // R5: full-period pulse starting just before a falling edge.
        @(posedge clk); #1.5 pad_in[0] = 1'b1;
        @(posedge clk); #1.5 pad_in[0] = 1'b0;
        @(posedge clk); #1;
        check("R5 fall-phase period pulse accepted", chg_pulse & 32'h1, 32'h1);
        idle(3);

        // R3: clear line 0 filter.
        bus_write(2'd1, 32'h1);
        en_m = model_clr(en_m, 32'h1);
        bus_read(2'd2, rd);
        check("R3 clear line0", rd, en_m);

        // R8 / R9: freeze with pad activity.
        pad_in = 32'h1234_5678;
        idle(4);
        @(posedge clk); #1 clk_en = 0;
        pad_in = 32'hFEDC_BA98;
        seen = '0;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1 seen |= chg_pulse;
        end
        check("R8 no pulses while gated", seen, '0);
        bus_read(2'd3, rd);
        check("R8 pin data frozen", rd, 32'h1234_5678);
        check("R9 periph live while gated", periph_in, 32'hFEDC_BA98);
        clk_en = 1;
        idle(3);
        bus_read(2'd3, rd);
        check("R8 pin data resumes", rd, 32'hFEDC_BA98);

        // Random section: set/clear sequences and rising-edge glitches.
        for (int it = 0; it < 40; it++) begin
            logic [LINES-1:0] s_w;
            logic [LINES-1:0] c_w;
            s_w = $urandom();
            c_w = $urandom() & $urandom();
            bus_write(2'd0, s_w);
            en_m = model_set(en_m, s_w);
            bus_write(2'd1, c_w);
            en_m = model_clr(en_m, c_w);
            bus_read(2'd2, rd);
            check("R2 R3 random set/clear status", rd, en_m);
            base = $urandom();
            @(negedge clk); #1 pad_in = base;
            idle(4);
            bus_read(2'd3, rd);
            check("R7 random steady pin data", rd, base);
            gm = $urandom();
            @(negedge clk); #1.2 pad_in = base ^ gm;
            @(posedge clk); #0.8 pad_in = base;
            check("R1 glitch seen only on unfiltered lines", chg_pulse, gm & ~en_m);
            @(posedge clk); #1;
            check("R10 return pulse on unfiltered lines", chg_pulse, gm & ~en_m);
            @(posedge clk); #1;
            check("R10 pulse lasts one cycle", chg_pulse, '0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule